// File: doc/BRIEF.md
# Card Access Strobe Sequencer

This block runs a single access to a removable 16-bit card. On an accepted request it reads three timing counts from the option fields of the chosen window: address setup, strobe length and hold. It then drives the card address, the chip select of the target slot and either the read or the write strobe, all counted in bus clock cycles. When the access has finished it raises a one-cycle completion pulse to the host. On a read, that pulse comes with the captured card data.

A long window setting could make an access overrun the host bus monitor. To prevent this, the sequencer limits the total active time of every access to one cycle less than a parameterised monitor limit, which is 60 cycles by default. Each slot also has two static outputs. One is a card reset, active high, that follows a per-slot control bit. The other is an active-low data-buffer enable, which is held off while the slot has no power.

Top module: `card_strobe_seq`

## Requirements
- R1: Each window option slice `win_opt[w*13 +: 13]` holds setup in bits [3:0], strobe length in bits [8:4] and hold in bits [12:9], all in bus clock cycles. The slice used is the one chosen by `req_win` at the cycle the request is accepted.
- R2: For the whole access, the target slot's `card_cs_n` bit is low, the other slots stay high and `card_addr` holds the request address. The access runs setup cycles with no strobe, then exactly the strobe-length cycles with the strobe low, then hold cycles.
- R3: A phase whose count is zero takes no cycle. With a zero strobe length the chip select stays low for setup plus hold cycles and no strobe is asserted.
- R4: A read (`req_write`=0) strobes `card_rd_n` only. A write (`req_write`=1) strobes `card_wr_n` only and drives the request data on `card_wdata`. The two strobes are never low together.
- R5: A read captures `card_rdata` on the last strobe cycle and presents it on `rdata` from the completion cycle on.
- R6: `done` is high for exactly one cycle: the (S+T+H+1)-th cycle after the accepting clock edge, where S, T and H are the effective counts. `busy` is low in the cycle after that.
- R7: If S+T+H reaches the bus-monitor limit (60), the counts are cut to a total of limit−1. The hold count is shortened first, then setup, then strobe.
- R8: A request is accepted only while the sequencer is idle. A request made while an access is in progress has no effect on the address, the slot or the timing, and it is not queued.
- R9: `card_rst[i]` is active high. It is 1 during reset and equals `slot_rst_ctl[i]` one cycle after that bit is driven.
- R10: `card_buf_oe_n[i]` is active low. It is 1 during reset and while `slot_pwr[i]` is 0, and it is 0 one cycle after `slot_pwr[i]` becomes 1.
- R11: During reset the sequencer is idle: `busy`=0, `done`=0, all `card_cs_n` bits are 1, and `card_rd_n` and `card_wr_n` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchroniser |
| req | input | 1 | Access request, taken only while idle |
| req_win | input | $clog2(NWIN) | Window whose timing fields are used |
| req_write | input | 1 | 1 = write, 0 = read |
| req_slot | input | $clog2(NSLOT) | Target slot |
| req_addr | input | ADDR_W | Card address |
| req_wdata | input | DATA_W | Write data |
| win_opt | input | NWIN*13 | Packed timing fields of all windows |
| card_rdata | input | DATA_W | Data from the card |
| slot_rst_ctl | input | NSLOT | Per-slot card reset control bit |
| slot_pwr | input | NSLOT | Per-slot powered indication |
| busy | output | 1 | Access in progress, including the done cycle |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Captured read data |
| card_addr | output | ADDR_W | Card address bus |
| card_wdata | output | DATA_W | Card write data |
| card_cs_n | output | NSLOT | Active-low chip select per slot |
| card_rd_n | output | 1 | Active-low read strobe |
| card_wr_n | output | 1 | Active-low write strobe |
| card_rst | output | NSLOT | Active-high card reset per slot |
| card_buf_oe_n | output | NSLOT | Active-low buffer output enable per slot |

## Verification
After an accepting edge, the completion pulse is due in cycle S+T+H+1. Every cycle before it is an active cycle, and the bench samples each one at the falling edge and classifies it as setup, strobe or hold from the strobe and chip-select pins. The measured phase lengths and the total are then compared with the effective counts listed in the table, including the capped windows. Read data is driven fresh on every strobe cycle, so the captured value shows which cycle was sampled. The slot reset and buffer-enable outputs are checked one cycle after their inputs change. An ignored request is checked by watching the address and the other slot's chip select for the rest of the running access.

// File: rtl/cs_seq_pkg.sv
package cs_seq_pkg;
  localparam int SETUP_W = 4;
  localparam int STRB_W  = 5;
  localparam int HOLD_W  = 4;
  localparam int OPT_W   = SETUP_W + STRB_W + HOLD_W;
  localparam int CNT_W   = STRB_W;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD, PH_DONE
  } phase_e;

  typedef struct packed {
    logic [SETUP_W-1:0] setup;
    logic [STRB_W-1:0]  strobe;
    logic [HOLD_W-1:0]  hold;
  } timing_t;

  typedef struct packed {
    phase_e           ph;
    logic [CNT_W-1:0] cnt;
  } step_t;

  // First non-empty phase at or after 'from' (0 setup, 1 strobe, 2 hold, 3 none).
  function automatic step_t first_phase(input logic [1:0] from, input timing_t t);
    step_t s;
    s.ph  = PH_DONE;
    s.cnt = '0;
    if (from == 2'd0 && t.setup != '0) begin
      s.ph  = PH_SETUP;
      s.cnt = CNT_W'(t.setup);
    end else if (from <= 2'd1 && t.strobe != '0) begin
      s.ph  = PH_STROBE;
      s.cnt = CNT_W'(t.strobe);
    end else if (from <= 2'd2 && t.hold != '0) begin
      s.ph  = PH_HOLD;
      s.cnt = CNT_W'(t.hold);
    end
    return s;
  endfunction
endpackage

// File: rtl/cs_win_timing.sv
module cs_win_timing
  import cs_seq_pkg::*;
#(
  parameter int NWIN      = 8,
  parameter int BUS_LIMIT = 60
) (
  input  logic [NWIN*OPT_W-1:0]   win_opt,
  input  logic [$clog2(NWIN)-1:0] win_sel,
  output timing_t                 eff
);
  localparam int unsigned MAX_ACTIVE = BUS_LIMIT - 1;

  logic [OPT_W-1:0] slice [NWIN];
  logic [OPT_W-1:0] sel;
  int unsigned vs, vt, vh, sum, ex, cut;

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    assign slice[g] = win_opt[g*OPT_W +: OPT_W];
  end

  // R1 field positions, R7 cap: hold shortened first, then setup, then strobe
  always_comb begin
    sel = slice[win_sel];
    vs  = 32'(sel[SETUP_W-1:0]);
    vt  = 32'(sel[SETUP_W +: STRB_W]);
    vh  = 32'(sel[SETUP_W+STRB_W +: HOLD_W]);
    sum = vs + vt + vh;
    ex  = (sum > MAX_ACTIVE) ? sum - MAX_ACTIVE : 0;
    cut = (ex < vh) ? ex : vh;
    vh  = vh - cut;
    ex  = ex - cut;
    cut = (ex < vs) ? ex : vs;
    vs  = vs - cut;
    ex  = ex - cut;
    cut = (ex < vt) ? ex : vt;
    vt  = vt - cut;
    eff.setup  = SETUP_W'(vs);
    eff.strobe = STRB_W'(vt);
    eff.hold   = HOLD_W'(vh);
  end
endmodule

// File: rtl/cs_phase_fsm.sv
module cs_phase_fsm
  import cs_seq_pkg::*;
#(
  parameter int NSLOT     = 2,
  parameter int ADDR_W    = 26,
  parameter int DATA_W    = 16,
  parameter int BUS_LIMIT = 60
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req,
  input  logic                     req_write,
  input  logic [$clog2(NSLOT)-1:0] req_slot,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  timing_t                  eff,
  input  logic [DATA_W-1:0]        card_rdata,
  output logic                     busy,
  output logic                     done,
  output logic [DATA_W-1:0]        rdata,
  output logic [ADDR_W-1:0]        card_addr,
  output logic [DATA_W-1:0]        card_wdata,
  output logic [NSLOT-1:0]         card_cs_n,
  output logic                     card_rd_n,
  output logic                     card_wr_n
);
  localparam int SLOT_W = $clog2(NSLOT);
  localparam int ACC_W  = $clog2(BUS_LIMIT + 1) + 1;

  phase_e              st_q;
  logic [CNT_W-1:0]    cnt_q;
  timing_t             tim_q;
  logic                wr_q;
  logic [SLOT_W-1:0]   slot_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wdata_q;
  logic [DATA_W-1:0]   rdata_q;
  step_t               nxt;
  logic                accept, active, cap_en;

  // next-state process
  always_comb begin
    nxt.ph  = st_q;
    nxt.cnt = cnt_q;
    accept  = 1'b0;
    unique case (st_q)
      PH_IDLE: if (req) begin
        accept = 1'b1;
        nxt    = first_phase(2'd0, eff);
      end
      PH_SETUP:
        if (cnt_q == CNT_W'(1)) nxt = first_phase(2'd1, tim_q);
        else                    nxt.cnt = cnt_q - 1'b1;
      PH_STROBE:
        if (cnt_q == CNT_W'(1)) nxt = first_phase(2'd2, tim_q);
        else                    nxt.cnt = cnt_q - 1'b1;
      PH_HOLD:
        if (cnt_q == CNT_W'(1)) nxt = first_phase(2'd3, tim_q);
        else                    nxt.cnt = cnt_q - 1'b1;
      PH_DONE: nxt.ph = PH_IDLE;
      default: nxt.ph = PH_IDLE;
    endcase
  end

  assign active = (st_q == PH_SETUP) || (st_q == PH_STROBE) || (st_q == PH_HOLD);
  assign cap_en = (st_q == PH_STROBE) && (cnt_q == CNT_W'(1)) && !wr_q;

  // register processes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= nxt.ph;
      cnt_q <= nxt.cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tim_q   <= '0;
      wr_q    <= 1'b0;
      slot_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      tim_q   <= eff;
      wr_q    <= req_write;
      slot_q  <= req_slot;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (cap_en) rdata_q <= card_rdata;
  end

  assign busy       = (st_q != PH_IDLE);
  assign done       = (st_q == PH_DONE);
  assign rdata      = rdata_q;
  assign card_addr  = addr_q;
  assign card_wdata = wdata_q;
  assign card_rd_n  = !((st_q == PH_STROBE) && !wr_q);
  assign card_wr_n  = !((st_q == PH_STROBE) && wr_q);

  for (genvar g = 0; g < NSLOT; g++) begin : g_cs
    assign card_cs_n[g] = !(active && (slot_q == SLOT_W'(g)));
  end

  // active-cycle counter used only by the bus-limit check
  logic [ACC_W-1:0] acc_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (active) acc_q <= acc_q + 1'b1;
    else             acc_q <= '0;
  end

  a_r7_bus_limit: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q <= ACC_W'(BUS_LIMIT - 1));
  a_r3_no_empty_phase: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt_q != '0));
  a_r2_strobe_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (!card_rd_n || !card_wr_n) |-> (card_cs_n != '1));
  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!card_rd_n && !card_wr_n));
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  a_r8_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(addr_q) && $stable(slot_q) && $stable(tim_q)));
endmodule

// File: rtl/cs_slot_ctl.sv
module cs_slot_ctl #(
  parameter int NSLOT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSLOT-1:0] rst_ctl,
  input  logic [NSLOT-1:0] pwr,
  output logic [NSLOT-1:0] card_rst,
  output logic [NSLOT-1:0] buf_oe_n
);
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        card_rst[g] <= 1'b1;
        buf_oe_n[g] <= 1'b1;
      end else begin
        card_rst[g] <= rst_ctl[g];
        buf_oe_n[g] <= !pwr[g];
      end
    end
  end

  logic p_valid;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) p_valid <= 1'b0;
    else        p_valid <= 1'b1;
  end

  a_r9_rst_follow: assert property (@(posedge clk) disable iff (!rst_n)
    p_valid |-> (card_rst == $past(rst_ctl)));
  a_r10_unpowered_off: assert property (@(posedge clk) disable iff (!rst_n)
    (p_valid && ($past(pwr) == '0)) |-> (buf_oe_n == '1));
endmodule

// File: rtl/card_strobe_seq.sv
module card_strobe_seq
  import cs_seq_pkg::*;
#(
  parameter int NWIN      = 8,
  parameter int NSLOT     = 2,
  parameter int ADDR_W    = 26,
  parameter int DATA_W    = 16,
  parameter int BUS_LIMIT = 60
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req,
  input  logic [$clog2(NWIN)-1:0]  req_win,
  input  logic                     req_write,
  input  logic [$clog2(NSLOT)-1:0] req_slot,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic [NWIN*OPT_W-1:0]    win_opt,
  input  logic [DATA_W-1:0]        card_rdata,
  input  logic [NSLOT-1:0]         slot_rst_ctl,
  input  logic [NSLOT-1:0]         slot_pwr,
  output logic                     busy,
  output logic                     done,
  output logic [DATA_W-1:0]        rdata,
  output logic [ADDR_W-1:0]        card_addr,
  output logic [DATA_W-1:0]        card_wdata,
  output logic [NSLOT-1:0]         card_cs_n,
  output logic                     card_rd_n,
  output logic                     card_wr_n,
  output logic [NSLOT-1:0]         card_rst,
  output logic [NSLOT-1:0]         card_buf_oe_n
);
  // asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_n_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_int = rsync_q[1];

  timing_t eff;

  cs_win_timing #(.NWIN(NWIN), .BUS_LIMIT(BUS_LIMIT)) u_timing (
    .win_opt (win_opt),
    .win_sel (req_win),
    .eff     (eff)
  );

  cs_phase_fsm #(
    .NSLOT(NSLOT), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUS_LIMIT(BUS_LIMIT)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .req        (req),
    .req_write  (req_write),
    .req_slot   (req_slot),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .eff        (eff),
    .card_rdata (card_rdata),
    .busy       (busy),
    .done       (done),
    .rdata      (rdata),
    .card_addr  (card_addr),
    .card_wdata (card_wdata),
    .card_cs_n  (card_cs_n),
    .card_rd_n  (card_rd_n),
    .card_wr_n  (card_wr_n)
  );

  cs_slot_ctl #(.NSLOT(NSLOT)) u_slot (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .rst_ctl  (slot_rst_ctl),
    .pwr      (slot_pwr),
    .card_rst (card_rst),
    .buf_oe_n (card_buf_oe_n)
  );
endmodule

// File: tb/card_strobe_seq_bench.sv
module card_strobe_seq_bench;
  localparam int NWIN = 8, NSLOT = 2, ADDR_W = 26, DATA_W = 16, OPT_W = 13;

  logic clk = 1'b0;
  logic rst_n, req, req_write;
  logic [2:0] req_win;
  logic [0:0] req_slot;
  logic [ADDR_W-1:0] req_addr, card_addr;
  logic [DATA_W-1:0] req_wdata, card_rdata, rdata, card_wdata;
  logic [NWIN*OPT_W-1:0] win_opt;
  logic [NSLOT-1:0] slot_rst_ctl, slot_pwr, card_cs_n, card_rst, card_buf_oe_n;
  logic busy, done, card_rd_n, card_wr_n;

  always #2 clk = ~clk;

  card_strobe_seq u_card_strobe_seq (
    .clk(clk), .rst_n(rst_n), .req(req), .req_win(req_win), .req_write(req_write),
    .req_slot(req_slot), .req_addr(req_addr), .req_wdata(req_wdata), .win_opt(win_opt),
    .card_rdata(card_rdata), .slot_rst_ctl(slot_rst_ctl), .slot_pwr(slot_pwr),
    .busy(busy), .done(done), .rdata(rdata), .card_addr(card_addr),
    .card_wdata(card_wdata), .card_cs_n(card_cs_n), .card_rd_n(card_rd_n),
    .card_wr_n(card_wr_n), .card_rst(card_rst), .card_buf_oe_n(card_buf_oe_n)
  );

  // window timing programmed into win_opt: setup, strobe, hold
  localparam int WS [NWIN] = '{2, 0, 3, 1, 0, 15, 15, 14};
  localparam int WT [NWIN] = '{3, 4, 0, 2, 0, 31, 30, 30};
  localparam int WH [NWIN] = '{1, 2, 2, 0, 0, 15, 15, 15};

  typedef struct packed {
    logic [2:0]        win;
    logic              wr;
    logic              slot;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        es, et, eh;   // expected effective counts
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 1'b0, 1'b0, 26'h0001000, 8'd2,  8'd3,  8'd1},
    '{3'd1, 1'b1, 1'b1, 26'h0002004, 8'd0,  8'd4,  8'd2},
    '{3'd2, 1'b1, 1'b0, 26'h0003008, 8'd3,  8'd0,  8'd2},
    '{3'd3, 1'b0, 1'b1, 26'h000400C, 8'd1,  8'd2,  8'd0},
    '{3'd4, 1'b0, 1'b0, 26'h0005010, 8'd0,  8'd0,  8'd0},
    '{3'd5, 1'b0, 1'b0, 26'h3FFFFFC, 8'd15, 8'd31, 8'd13},
    '{3'd6, 1'b1, 1'b1, 26'h2AAAAAA, 8'd15, 8'd30, 8'd14},
    '{3'd7, 1'b0, 1'b1, 26'h1555555, 8'd14, 8'd30, 8'd15}
  };

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic string vec_tag(input int i);
    case (i)
      1, 2, 3, 4: return "R3 zero-phase";
      5, 6:       return "R7 capped";
      default:    return "R1 R2 window";
    endcase
  endfunction

  task automatic run_vec(input int i);
    vec_t v = VEC[i];
    int exp_s = v.es, exp_t = v.et, exp_h = v.eh;
    int ms = 0, mt = 0, mh = 0, cyc = 0, bad = 0;
    bit seen = 1'b0;
    logic [DATA_W-1:0] wd = 16'h5A00 + 16'(i);
    logic [DATA_W-1:0] base = 16'h1000 * 16'(i + 1);
    string tg = vec_tag(i);
    if (exp_t == 0) begin exp_s += exp_h; exp_h = 0; end
    @(negedge clk);
    req = 1'b1; req_win = v.win; req_write = v.wr; req_slot = v.slot;
    req_addr = v.addr; req_wdata = wd;
    @(negedge clk);
    req = 1'b0;
    while (!done && cyc < 200) begin
      if (card_cs_n[v.slot] !== 1'b0 || card_cs_n[!v.slot] !== 1'b1 || card_addr !== v.addr) bad++;
      if (!card_rd_n || !card_wr_n) begin
        mt++; seen = 1'b1;
        if ((v.wr && !card_rd_n) || (!v.wr && !card_wr_n)) bad++;
        if (v.wr && card_wdata !== wd) bad++;
        if (!v.wr) card_rdata = base + 16'(mt);
      end else if (!seen) ms++;
      else mh++;
      cyc++;
      @(negedge clk);
    end
    check(done === 1'b1, {tg, " R6 done reached"}, done, 1);
    check(cyc == exp_s + exp_t + exp_h, {tg, " R6 latency"}, cyc, exp_s + exp_t + exp_h);
    check(ms == exp_s, {tg, " R2 setup len"}, ms, exp_s);
    check(mt == exp_t, {tg, " R2 strobe len"}, mt, exp_t);
    check(mh == exp_h, {tg, " R2 hold len"}, mh, exp_h);
    check(bad == 0, {tg, " R2 R4 pins during access"}, bad, 0);
    if (!v.wr && exp_t != 0)
      check(rdata == base + 16'(exp_t), {tg, " R5 read capture"}, rdata, base + 16'(exp_t));
    @(negedge clk);
    check(!done && !busy, {tg, " R6 single pulse"}, {done, busy}, 0);
  endtask

  initial begin
    rst_n = 1'b0; req = 1'b0; req_win = '0; req_write = 1'b0; req_slot = '0;
    req_addr = '0; req_wdata = '0; card_rdata = '0;
    slot_rst_ctl = '0; slot_pwr = '0;
    for (int w = 0; w < NWIN; w++)
      win_opt[w*OPT_W +: OPT_W] = {4'(WH[w]), 5'(WT[w]), 4'(WS[w])};
    repeat (3) @(negedge clk);
    // R11 reset state
    check(busy == 1'b0 && done == 1'b0, "R11 idle in reset", {busy, done}, 0);
    check(card_cs_n == '1 && card_rd_n && card_wr_n, "R11 strobes off", {card_cs_n, card_rd_n, card_wr_n}, 4'hF);
    check(card_rst == '1, "R9 reset value", card_rst, 2'b11);
    check(card_buf_oe_n == '1, "R10 reset value", card_buf_oe_n, 2'b11);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // table of accesses
    for (int i = 0; i < NV; i++) run_vec(i);

    // R8: request during an access is ignored and not queued
    begin
      int cyc = 0, bad = 0, idle_bad = 0;
      @(negedge clk);
      req = 1'b1; req_win = 3'd0; req_write = 1'b0; req_slot = 1'b0; req_addr = 26'h0ABCDEF;
      @(negedge clk);
      req_win = 3'd4; req_slot = 1'b1; req_addr = 26'h0123456;
      @(negedge clk);
      if (card_addr !== 26'h0ABCDEF || card_cs_n[1] !== 1'b1) bad++;
      cyc = 1;
      req = 1'b0;
      while (!done && cyc < 100) begin
        if (card_addr !== 26'h0ABCDEF || card_cs_n[1] !== 1'b1) bad++;
        cyc++;
        @(negedge clk);
      end
      check(bad == 0, "R8 busy request ignored", bad, 0);
      check(cyc == 6, "R8 running access length kept", cyc, 6);
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        if (busy) idle_bad++;
      end
      check(idle_bad == 0, "R8 no queued access", idle_bad, 0);
    end

    // R9 / R10 slot controls
    @(negedge clk);
    slot_pwr = 2'b01; slot_rst_ctl = 2'b10;
    @(negedge clk);
    check(card_buf_oe_n == 2'b10, "R10 powered slot enabled", card_buf_oe_n, 2'b10);
    check(card_rst == 2'b10, "R9 reset follows control", card_rst, 2'b10);
    slot_pwr = 2'b10; slot_rst_ctl = 2'b01;
    @(negedge clk);
    check(card_buf_oe_n == 2'b01, "R10 enable swaps", card_buf_oe_n, 2'b01);
    check(card_rst == 2'b01, "R9 reset swaps", card_rst, 2'b01);
    slot_pwr = 2'b00;
    @(negedge clk);
    check(card_buf_oe_n == 2'b11, "R10 unpowered off", card_buf_oe_n, 2'b11);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL R6 watchdog expired: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule